// File: doc/BRIEF.md
# Windowed Register Index Mapper

This block turns a logical integer register number into an index into a flat physical register file, for a processor whose register windows overlap and whose global registers come in several banks. It holds the two pieces of state that steer the translation: the current window pointer and the global bank level. Each has its own write port. A lookup port takes a logical register number and a view selector. The view selector picks the current window or one of its two neighbours. The lookup port returns the physical index in the same cycle.

The physical file is laid out in three parts. The global banks come first, eight entries per bank. The windowed area follows, sixteen entries per window, treated as a ring. A small set of microcode scratch registers sits at the end. A window shows 24 registers. The stride between windows is 16, so the 8 registers at one edge of a window land on the same physical entries as the 8 at the opposite edge of the adjacent window. Neighbouring windows can then pass values without any copy. The block computes the three window views side by side, so a neighbour lookup costs no more time than a current-window lookup.

Top module: `wrmap_top`

## Requirements
- R1: While `rst` is high on a rising clock edge, the window pointer and the global level both become 0, and both stay at 0 until they are written.
- R2: Logical register 0 maps to physical index 0 for every global level and every view.
- R3: Logical registers 1 to 7 map to physical index `lreg + 8*gl_q`.
- R4: Logical registers 8 to 31 are windowed. With offset `i = lreg - 8` and window `w`, they map to `NUM_GLV*8 + ((i - 16*w + 16*NUM_WIN) mod (16*NUM_WIN))`. The current view (`view` = 0, and also the unused code 3) uses `w = cwp_q`.
- R5: View code 1 (next) uses `w = (cwp_q - 1) mod NUM_WIN`, so window 0 wraps to `NUM_WIN-1`.
- R6: View code 2 (previous) uses `w = (cwp_q + 1) mod NUM_WIN`, so window `NUM_WIN-1` wraps to 0.
- R7: In the current view, logical register `24+k` (k = 0..7) gives the same physical index as logical register `8+k` in the next view.
- R8: When `cwp_we` is high, the window pointer takes `cwp_wdata` on the next edge. A value of `NUM_WIN` or more is stored as `NUM_WIN-1`.
- R9: When `gl_we` is high, the global level takes `gl_wdata` on the next edge. A value of `NUM_GLV` or more is stored as `NUM_GLV-1`.
- R10: When a write enable is low, the matching register keeps its value, whatever its write data port carries.
- R11: Logical registers from 32 to `32+NUM_MICRO-1` map to `NUM_GLV*8 + 16*NUM_WIN + (lreg - 32)`, whatever the window and the level.
- R12: A logical number at or above `32+NUM_MICRO` maps to physical index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cwp_we | input | 1 | Window pointer write enable |
| cwp_wdata | input | CWP_IN_W | Window pointer write value, clamped |
| gl_we | input | 1 | Global level write enable |
| gl_wdata | input | GL_IN_W | Global level write value, clamped |
| lreg | input | 6 | Logical register number |
| view | input | 2 | 0 current, 1 next, 2 previous, 3 current |
| cwp_q | output | CWP_W | Stored window pointer |
| gl_q | output | GL_W | Stored global level |
| phys_idx | output | PHYS_W | Physical register index |

## Verification
Every logical number is swept in all three views at the lowest window, at a middle window and at the top window. The two end windows show whether the ring wraps correctly in both directions. The middle window shows whether the stride sign and the neighbour offsets are right. A pairwise comparison of current-view high registers against next-view low registers checks the overlap, and it does not depend on the absolute formula. Writes just inside the range, at the range edge and far past it tell a clamp apart from a truncation, and write data driven while the enables are low confirms that the stored state holds.

// File: rtl/wrmap_pkg.sv
package wrmap_pkg;

    localparam int LREG_W       = 6;
    localparam int GLB_BANK     = 8;
    localparam int WIN_STRIDE   = 16;
    localparam int WIN_VIEW     = 24;
    localparam int LREG_WIN_LO  = 8;
    localparam int LREG_MIC_LO  = 32;
    localparam int OFF_W        = 5;

    typedef enum logic [1:0] {
        VIEW_CUR  = 2'd0,
        VIEW_NEXT = 2'd1,
        VIEW_PREV = 2'd2,
        VIEW_RSVD = 2'd3
    } view_e;

    typedef enum logic [2:0] {
        CLS_ZERO   = 3'd0,
        CLS_GLOBAL = 3'd1,
        CLS_WIN    = 3'd2,
        CLS_MICRO  = 3'd3,
        CLS_NONE   = 3'd4
    } lcls_e;

    typedef struct packed {
        lcls_e            cls;
        logic [OFF_W-1:0] off;
    } lreg_dec_t;

    // Split a logical number into its class and the offset inside that class.
    function automatic lreg_dec_t decode_lreg(input logic [LREG_W-1:0] l, input int num_micro);
        lreg_dec_t d;
        int li;
        li = int'(l);
        d.off = '0;
        if (li == 0) begin
            d.cls = CLS_ZERO;
        end else if (li < LREG_WIN_LO) begin
            d.cls = CLS_GLOBAL;
            d.off = OFF_W'(li);
        end else if (li < LREG_MIC_LO) begin
            d.cls = CLS_WIN;
            d.off = OFF_W'(li - LREG_WIN_LO);
        end else if (li < LREG_MIC_LO + num_micro) begin
            d.cls = CLS_MICRO;
            d.off = OFF_W'(li - LREG_MIC_LO);
        end else begin
            d.cls = CLS_NONE;
        end
        return d;
    endfunction

    // Amount added to the pointer (mod windows) for view slot 0, 1, 2.
    function automatic int view_step(input int slot, input int num_win);
        if (slot == 1) return num_win - 1;
        if (slot == 2) return 1;
        return 0;
    endfunction

endpackage

// File: rtl/wrmap_state.sv
module wrmap_state #(
    parameter int NUM_WIN  = 8,
    parameter int NUM_GLV  = 4,
    parameter int CWP_IN_W = 8,
    parameter int GL_IN_W  = 3,
    parameter int CWP_W    = 3,
    parameter int GL_W     = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cwp_we,
    input  logic [CWP_IN_W-1:0] cwp_wdata,
    input  logic                gl_we,
    input  logic [GL_IN_W-1:0]  gl_wdata,
    output logic [CWP_W-1:0]    cwp_r,
    output logic [GL_W-1:0]     gl_r
);

    logic [CWP_W-1:0] cwp_nx;
    logic [GL_W-1:0]  gl_nx;

    always_comb begin
        if (int'(cwp_wdata) >= NUM_WIN)
            cwp_nx = CWP_W'(NUM_WIN - 1);
        else
            cwp_nx = CWP_W'(cwp_wdata);
        if (int'(gl_wdata) >= NUM_GLV)
            gl_nx = GL_W'(NUM_GLV - 1);
        else
            gl_nx = GL_W'(gl_wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp_r <= '0;
            gl_r  <= '0;
        end else begin
            if (cwp_we) cwp_r <= cwp_nx;
            if (gl_we)  gl_r  <= gl_nx;
        end
    end

endmodule

// File: rtl/wrmap_win_rot.sv
module wrmap_win_rot
    import wrmap_pkg::*;
#(
    parameter int NUM_WIN   = 8,
    parameter int GLB_TOTAL = 32,
    parameter int CWP_W     = 3,
    parameter int PHYS_W    = 8,
    parameter int STEP      = 0
) (
    input  logic [CWP_W-1:0]  cwp,
    input  logic [OFF_W-1:0]  off,
    output logic [PHYS_W-1:0] phys
);

    localparam int TOT_WIN = NUM_WIN * WIN_STRIDE;
    localparam int RW      = $clog2(TOT_WIN + WIN_VIEW) + 1;
    localparam int SW      = CWP_W + 1;

    logic [SW-1:0]    wsum;
    logic [CWP_W-1:0] weff;
    logic [RW-1:0]    pos;

    always_comb begin
        // Neighbour window, wrapped without ever going negative.
        wsum = {1'b0, cwp} + SW'(STEP);
        if (wsum >= SW'(NUM_WIN))
            wsum = wsum - SW'(NUM_WIN);
        weff = wsum[CWP_W-1:0];
        // Ring position: offset minus window base, biased by one full ring.
        pos = RW'(off) + RW'(TOT_WIN) - (RW'(weff) << 4);
        if (pos >= RW'(TOT_WIN))
            pos = pos - RW'(TOT_WIN);
        phys = PHYS_W'(GLB_TOTAL) + PHYS_W'(pos);
    end

endmodule

// File: rtl/wrmap_flat.sv
module wrmap_flat
    import wrmap_pkg::*;
#(
    parameter int MIC_BASE = 160,
    parameter int GL_W     = 2,
    parameter int PHYS_W   = 8
) (
    input  logic [OFF_W-1:0]  off,
    input  logic [GL_W-1:0]   gl,
    output logic [PHYS_W-1:0] glob_idx,
    output logic [PHYS_W-1:0] mic_idx
);

    always_comb begin
        glob_idx = PHYS_W'(off) + (PHYS_W'(gl) << 3);
        mic_idx  = PHYS_W'(MIC_BASE) + PHYS_W'(off);
    end

endmodule

// File: rtl/wrmap_top.sv
module wrmap_top
    import wrmap_pkg::*;
#(
    parameter int NUM_WIN   = 8,
    parameter int NUM_GLV   = 4,
    parameter int NUM_MICRO = 8,
    parameter int CWP_IN_W  = 8,
    parameter int GL_IN_W   = 3,
    parameter int CWP_W     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
    parameter int GL_W      = (NUM_GLV > 1) ? $clog2(NUM_GLV) : 1,
    parameter int PHYS_W    = $clog2(NUM_GLV*GLB_BANK + NUM_WIN*WIN_STRIDE + NUM_MICRO)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cwp_we,
    input  logic [CWP_IN_W-1:0] cwp_wdata,
    input  logic                gl_we,
    input  logic [GL_IN_W-1:0]  gl_wdata,
    input  logic [LREG_W-1:0]   lreg,
    input  logic [1:0]          view,
    output logic [CWP_W-1:0]    cwp_q,
    output logic [GL_W-1:0]     gl_q,
    output logic [PHYS_W-1:0]   phys_idx
);

    localparam int GLB_TOTAL = NUM_GLV * GLB_BANK;
    localparam int TOT_WIN   = NUM_WIN * WIN_STRIDE;
    localparam int MIC_BASE  = GLB_TOTAL + TOT_WIN;
    localparam int NVIEW     = 3;

    lreg_dec_t         dec;
    logic [PHYS_W-1:0] win_idx [NVIEW];
    logic [PHYS_W-1:0] glob_idx;
    logic [PHYS_W-1:0] mic_idx;
    logic [1:0]        vslot;

    wrmap_state #(
        .NUM_WIN(NUM_WIN), .NUM_GLV(NUM_GLV), .CWP_IN_W(CWP_IN_W),
        .GL_IN_W(GL_IN_W), .CWP_W(CWP_W), .GL_W(GL_W)
    ) u_state (
        .clk(clk), .rst(rst),
        .cwp_we(cwp_we), .cwp_wdata(cwp_wdata),
        .gl_we(gl_we), .gl_wdata(gl_wdata),
        .cwp_r(cwp_q), .gl_r(gl_q)
    );

    always_comb dec = decode_lreg(lreg, NUM_MICRO);

    // All three window views are computed side by side.
    for (genvar v = 0; v < NVIEW; v++) begin : g_view
        wrmap_win_rot #(
            .NUM_WIN(NUM_WIN), .GLB_TOTAL(GLB_TOTAL), .CWP_W(CWP_W),
            .PHYS_W(PHYS_W), .STEP(view_step(v, NUM_WIN))
        ) u_rot (
            .cwp(cwp_q), .off(dec.off), .phys(win_idx[v])
        );
    end

    wrmap_flat #(
        .MIC_BASE(MIC_BASE), .GL_W(GL_W), .PHYS_W(PHYS_W)
    ) u_flat (
        .off(dec.off), .gl(gl_q), .glob_idx(glob_idx), .mic_idx(mic_idx)
    );

    always_comb begin
        case (view_e'(view))
            VIEW_NEXT: vslot = 2'd1;
            VIEW_PREV: vslot = 2'd2;
            default:   vslot = 2'd0;
        endcase
    end

    always_comb begin
        case (dec.cls)
            CLS_GLOBAL: phys_idx = glob_idx;
            CLS_WIN:    phys_idx = win_idx[vslot];
            CLS_MICRO:  phys_idx = mic_idx;
            default:    phys_idx = '0;
        endcase
    end

endmodule

// File: rtl/wrmap_chk.sv
module wrmap_chk #(
    parameter int NUM_WIN   = 8,
    parameter int NUM_GLV   = 4,
    parameter int NUM_MICRO = 8,
    parameter int CWP_IN_W  = 8,
    parameter int GL_IN_W   = 3,
    parameter int CWP_W     = 3,
    parameter int GL_W      = 2,
    parameter int PHYS_W    = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                cwp_we,
    input logic [CWP_IN_W-1:0] cwp_wdata,
    input logic                gl_we,
    input logic [GL_IN_W-1:0]  gl_wdata,
    input logic [5:0]          lreg,
    input logic [CWP_W-1:0]    cwp_q,
    input logic [GL_W-1:0]     gl_q,
    input logic [PHYS_W-1:0]   phys_idx
);

    localparam int GT = NUM_GLV * 8;
    localparam int TW = NUM_WIN * 16;

    a_r2_zero_reg: assert property (@(posedge clk) disable iff (rst)
        (lreg == 6'd0) |-> (phys_idx == '0));

    a_r3_global_bank: assert property (@(posedge clk) disable iff (rst)
        (lreg != 6'd0 && int'(lreg) < 8) |-> (int'(phys_idx) < GT && int'(phys_idx) >= 8*int'(gl_q)));

    a_r4_window_range: assert property (@(posedge clk) disable iff (rst)
        (int'(lreg) >= 8 && int'(lreg) < 32) |-> (int'(phys_idx) >= GT && int'(phys_idx) < GT + TW));

    a_r8_cwp_clamp: assert property (@(posedge clk) disable iff (rst)
        (cwp_we && int'(cwp_wdata) >= NUM_WIN) |=> (int'(cwp_q) == NUM_WIN - 1));

    a_r8_cwp_range: assert property (@(posedge clk) disable iff (rst)
        int'(cwp_q) < NUM_WIN);

    a_r9_gl_range: assert property (@(posedge clk) disable iff (rst)
        int'(gl_q) < NUM_GLV);

    a_r10_cwp_hold: assert property (@(posedge clk) disable iff (rst)
        !cwp_we |=> $stable(cwp_q));

    a_r10_gl_hold: assert property (@(posedge clk) disable iff (rst)
        !gl_we |=> $stable(gl_q));

    a_r11_micro: assert property (@(posedge clk) disable iff (rst)
        (int'(lreg) >= 32 && int'(lreg) < 32 + NUM_MICRO) |-> (int'(phys_idx) == GT + TW + int'(lreg) - 32));

    a_r12_unmapped: assert property (@(posedge clk) disable iff (rst)
        (int'(lreg) >= 32 + NUM_MICRO) |-> (phys_idx == '0));

endmodule

bind wrmap_top wrmap_chk #(
    .NUM_WIN(NUM_WIN), .NUM_GLV(NUM_GLV), .NUM_MICRO(NUM_MICRO),
    .CWP_IN_W(CWP_IN_W), .GL_IN_W(GL_IN_W), .CWP_W(CWP_W),
    .GL_W(GL_W), .PHYS_W(PHYS_W)
) u_chk (
    .clk(clk), .rst(rst), .cwp_we(cwp_we), .cwp_wdata(cwp_wdata),
    .gl_we(gl_we), .gl_wdata(gl_wdata), .lreg(lreg),
    .cwp_q(cwp_q), .gl_q(gl_q), .phys_idx(phys_idx)
);

// File: tb/sim_wrmap_top.sv
module sim_wrmap_top;

    localparam int NW = 8;
    localparam int NG = 4;
    localparam int NM = 8;
    localparam int GT = NG * 8;
    localparam int TW = NW * 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cwp_we = 1'b0;
    logic [7:0] cwp_wdata = '0;
    logic       gl_we = 1'b0;
    logic [2:0] gl_wdata = '0;
    logic [5:0] lreg = '0;
    logic [1:0] view = '0;
    logic [2:0] cwp_q;
    logic [1:0] gl_q;
    logic [7:0] phys_idx;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wrmap_top u0 (
        .clk(clk), .rst(rst), .cwp_we(cwp_we), .cwp_wdata(cwp_wdata),
        .gl_we(gl_we), .gl_wdata(gl_wdata), .lreg(lreg), .view(view),
        .cwp_q(cwp_q), .gl_q(gl_q), .phys_idx(phys_idx)
    );

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    function automatic int model(input int l, input int v, input int c, input int g);
        int w;
        if (l == 0) return 0;
        if (l < 8) return l + 8 * g;
        if (l < 32) begin
            w = (v == 1) ? (c + NW - 1) % NW : (v == 2) ? (c + 1) % NW : c;
            return GT + (((l - 8) - 16 * w + TW) % TW);
        end
        if (l < 32 + NM) return GT + TW + l - 32;
        return 0;
    endfunction

    task automatic look(input int l, input int v, output int res);
        @(negedge clk);
        lreg = 6'(l);
        view = 2'(v);
        #1;
        res = int'(phys_idx);
    endtask

    task automatic wr_cwp(input int val);
        @(negedge clk);
        cwp_we = 1'b1;
        cwp_wdata = 8'(val);
        @(negedge clk);
        cwp_we = 1'b0;
        #1;
    endtask

    task automatic wr_gl(input int val);
        @(negedge clk);
        gl_we = 1'b1;
        gl_wdata = 3'(val);
        @(negedge clk);
        gl_we = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 cwp after reset", int'(cwp_q), 0);
        chk("R1 gl after reset", int'(gl_q), 0);
    endtask

    task automatic t_globals;
        int r;
        for (int g = 0; g < NG; g++) begin
            wr_gl(g);
            for (int v = 0; v < 4; v++) begin
                look(0, v, r);
                chk("R2 zero register", r, 0);
            end
            for (int l = 1; l < 8; l++) begin
                look(l, 0, r);
                chk("R3 global bank", r, l + 8 * g);
            end
        end
        wr_gl(0);
    endtask

    task automatic t_window_sweep(input int c);
        int r;
        wr_cwp(c);
        chk("R8 cwp in range", int'(cwp_q), c);
        for (int l = 8; l < 32; l++) begin
            look(l, 0, r);
            chk("R4 current view", r, model(l, 0, c, 0));
            look(l, 3, r);
            chk("R4 code 3 as current", r, model(l, 0, c, 0));
            look(l, 1, r);
            chk("R5 next view", r, model(l, 1, c, 0));
            look(l, 2, r);
            chk("R6 previous view", r, model(l, 2, c, 0));
        end
    endtask

    task automatic t_wrap_ends;
        int r;
        wr_cwp(0);
        look(8, 1, r);
        chk("R5 next wraps at window 0", r, GT + 16);
        wr_cwp(NW - 1);
        look(8, 2, r);
        chk("R6 previous wraps at top window", r, GT);
    endtask

    task automatic t_alias;
        int a;
        int b;
        int cs [3] = '{0, 3, NW - 1};
        foreach (cs[j]) begin
            wr_cwp(cs[j]);
            for (int k = 0; k < 8; k++) begin
                look(24 + k, 0, a);
                look(8 + k, 1, b);
                chk("R7 ins alias next outs", a, b);
            end
        end
    endtask

    task automatic t_clamp;
        wr_cwp(NW);
        chk("R8 clamp at edge", int'(cwp_q), NW - 1);
        wr_cwp(2);
        wr_cwp(200);
        chk("R8 clamp far above", int'(cwp_q), NW - 1);
        wr_gl(NG - 1);
        chk("R9 gl top value", int'(gl_q), NG - 1);
        wr_gl(1);
        wr_gl(6);
        chk("R9 gl clamp", int'(gl_q), NG - 1);
    endtask

    task automatic t_hold;
        int r;
        wr_cwp(5);
        wr_gl(2);
        @(negedge clk);
        cwp_wdata = 8'd1;
        gl_wdata = 3'd0;
        repeat (3) @(negedge clk);
        #1;
        chk("R10 cwp holds", int'(cwp_q), 5);
        chk("R10 gl holds", int'(gl_q), 2);
        look(3, 0, r);
        chk("R10 global uses held level", r, 3 + 16);
    endtask

    task automatic t_micro_and_unmapped;
        int r;
        int cs [2] = '{1, NW - 1};
        foreach (cs[j]) begin
            wr_cwp(cs[j]);
            wr_gl(j + 1);
            for (int l = 32; l < 32 + NM; l++) begin
                look(l, j, r);
                chk("R11 microcode register", r, GT + TW + l - 32);
            end
        end
        for (int l = 32 + NM; l < 64; l++) begin
            look(l, 0, r);
            chk("R12 unmapped number", r, 0);
        end
    endtask

    initial begin
        t_reset();
        t_globals();
        t_window_sweep(0);
        t_window_sweep(4);
        t_window_sweep(NW - 1);
        t_wrap_ends();
        t_alias();
        t_clamp();
        t_hold();
        t_micro_and_unmapped();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule